// File: doc/BRIEF.md
# JTAG Instruction Register Scan Sequencer

This block writes an instruction into one chosen TAP of a daisy chain. A host gives it the instruction value and three chain figures: how many instruction bits belong to the devices ahead of the target, the target's own instruction length, and how many instruction bits follow it. On a start pulse the block drives TCK, TMS and TDI to move the TAP controllers from Run-Test/Idle to Shift-IR and back to idle. Every device other than the target receives all ones, so each of them selects BYPASS.

Each bit is one TCK period made by an internal timer. TCK falls while TMS and TDI are updated, then rises so the chain samples them. Between scans TCK and TDI rest high and TMS rests low. A scan ends with a one-cycle done pulse. A length of zero, or a length above the instruction width, ends at once with done and error and no TCK edge.

Top module: `jtag_ir_scan`

## Requirements
- R1: After reset, and whenever no scan is running, tck is 1, tdi is 1, tms is 0 and busy is 0.
- R2: A scan opens with four TCK periods whose TMS values are 1, 1, 0, 0, with TDI at 1.
- R3: In Shift-IR, one period with TDI at 1 and TMS at 0 is sent for each pad bit ahead of the target (pre_bits). A count of zero sends none.
- R4: The target bits follow, ir_value bit 0 first, one per period.
- R5: TMS is 1 on exactly one shifted bit, the final one of the chain. When post_bits is 0 this is the target's most significant bit (bit ir_len-1). Otherwise the target's last bit goes out with TMS 0, and post_bits periods with TDI at 1 follow, the last of them with TMS 1.
- R6: After the shift, two periods are sent with TMS 1 then 0, both with TDI at 1, so the scan has 6 + pre_bits + ir_len + post_bits periods in total.
- R7: TMS and TDI change only while TCK is low. Each period holds TCK low for HALF_CYC clock cycles and then high for HALF_CYC + 1 cycles.
- R8: busy is 1 from the cycle after an accepted start until the scan ends. done pulses for one cycle at the end, with err 0.
- R9: A start with ir_len of 0 or above IR_W produces done and err together in the next cycle, with no TCK edge.
- R10: A start while busy is ignored: the running scan's bit stream and length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, taken while idle |
| ir_value | input | 32 | Instruction for the target, LSB shifted first |
| pre_bits | input | 8 | Instruction bits of devices ahead of the target |
| ir_len | input | 6 | Target instruction length, 1 to 32 |
| post_bits | input | 8 | Instruction bits of devices after the target |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| err | output | 1 | Length rejected, set together with done |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the chain |

## Verification
The bench captures TMS and TDI on every TCK rising edge and compares the whole stream with one built from the requirements. Scans run with no padding, with leading padding only, with trailing padding only, and with both. These separate the two ways of placing the final TMS high and show that pad bits are ones kept apart from the target bits. The one-bit and full 32-bit lengths check the edges of the target phase. A zero length and an oversize length check the error path, and a second start sent in the middle of a scan checks that a running scan is not disturbed.

// File: rtl/jis_pkg.sv
package jis_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT} seq_st_t;
  typedef enum logic [2:0] {PH_HDR, PH_PRE, PH_TGT, PH_POST, PH_TAIL} seq_ph_t;
endpackage

// File: rtl/jis_tck_gen.sv
module jis_tck_gen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic tms_in,
  input  logic tdi_in,
  output logic bit_end,
  output logic tck,
  output logic tms,
  output logic tdi
);
  localparam int TW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [TW-1:0] TLAST = TW'(HALF_CYC - 1);

  logic          act_q, act_d, hi_q, hi_d, tck_q, tck_d, tms_q, tms_d, tdi_q, tdi_d;
  logic [TW-1:0] tmr_q, tmr_d;

  assign bit_end = act_q & hi_q & (tmr_q == TLAST);

  always_comb begin
    act_d = act_q; hi_d = hi_q; tck_d = tck_q;
    tms_d = tms_q; tdi_d = tdi_q; tmr_d = tmr_q;
    if (load) begin
      act_d = 1'b1; hi_d = 1'b0; tck_d = 1'b0;
      tms_d = tms_in; tdi_d = tdi_in; tmr_d = '0;
    end else if (act_q) begin
      if (tmr_q == TLAST) begin
        tmr_d = '0;
        if (!hi_q) begin
          hi_d  = 1'b1;
          tck_d = 1'b1;
        end else begin
          act_d = 1'b0;
        end
      end else begin
        tmr_d = tmr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0; hi_q <= 1'b0; tck_q <= 1'b1;
      tms_q <= 1'b0; tdi_q <= 1'b1; tmr_q <= '0;
    end else begin
      act_q <= act_d; hi_q <= hi_d; tck_q <= tck_d;
      tms_q <= tms_d; tdi_q <= tdi_d; tmr_q <= tmr_d;
    end
  end

  assign tck = tck_q;
  assign tms = tms_q;
  assign tdi = tdi_q;
endmodule

// File: rtl/jis_seq.sv
module jis_seq
  import jis_pkg::*;
#(
  parameter int IR_W  = 32,
  parameter int CNT_W = 8,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IR_W-1:0]  ir_value,
  input  logic [CNT_W-1:0] pre_bits,
  input  logic [LEN_W-1:0] ir_len,
  input  logic [CNT_W-1:0] post_bits,
  input  logic             bit_end,
  output logic             load,
  output logic             bit_tms,
  output logic             bit_tdi,
  output logic             busy,
  output logic             done,
  output logic             err
);
  seq_st_t          st_q, st_d;
  seq_ph_t          ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, pre_q, pre_d, len_q, len_d, post_q, post_d;
  logic [IR_W-1:0]  sr_q, sr_d;
  logic             done_q, done_d, err_q, err_d, last_bit, len_bad;

  assign len_bad  = (ir_len == '0) || (int'(ir_len) > IR_W);
  assign last_bit = (ph_q == PH_TAIL) && (cnt_q == CNT_W'(1));

  always_comb begin
    bit_tms = 1'b0;
    bit_tdi = 1'b1;
    case (ph_q)
      PH_HDR:  bit_tms = (cnt_q < CNT_W'(2));
      PH_TGT:  begin
        bit_tdi = sr_q[0];
        bit_tms = (cnt_q == len_q - 1'b1) && (post_q == '0);
      end
      PH_POST: bit_tms = (cnt_q == post_q - 1'b1);
      PH_TAIL: bit_tms = (cnt_q == '0);
      default: ;
    endcase
  end

  always_comb begin
    st_d = st_q; ph_d = ph_q; cnt_d = cnt_q; sr_d = sr_q;
    pre_d = pre_q; len_d = len_q; post_d = post_q;
    done_d = 1'b0; err_d = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        if (len_bad) begin
          done_d = 1'b1;
          err_d  = 1'b1;
        end else begin
          st_d = ST_LOAD; ph_d = PH_HDR; cnt_d = '0; sr_d = ir_value;
          pre_d = pre_bits; len_d = CNT_W'(ir_len); post_d = post_bits;
        end
      end
      ST_LOAD: st_d = ST_WAIT;
      ST_WAIT: if (bit_end) begin
        if (last_bit) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
        end else begin
          st_d  = ST_LOAD;
          cnt_d = cnt_q + 1'b1;
          case (ph_q)
            PH_HDR: if (cnt_q == CNT_W'(3)) begin
              cnt_d = '0;
              ph_d  = (pre_q != '0) ? PH_PRE : PH_TGT;
            end
            PH_PRE: if (cnt_q == pre_q - 1'b1) begin
              cnt_d = '0; ph_d = PH_TGT;
            end
            PH_TGT: begin
              sr_d = sr_q >> 1;
              if (cnt_q == len_q - 1'b1) begin
                cnt_d = '0;
                ph_d  = (post_q != '0) ? PH_POST : PH_TAIL;
              end
            end
            PH_POST: if (cnt_q == post_q - 1'b1) begin
              cnt_d = '0; ph_d = PH_TAIL;
            end
            default: ;
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ph_q <= PH_HDR; cnt_q <= '0; sr_q <= '0;
      pre_q <= '0; len_q <= '0; post_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; cnt_q <= cnt_d; sr_q <= sr_d;
      pre_q <= pre_d; len_q <= len_d; post_q <= post_d; done_q <= done_d; err_q <= err_d;
    end
  end

  assign load = (st_q == ST_LOAD);
  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
  assign err  = err_q;
endmodule

// File: rtl/jtag_ir_scan.sv
module jtag_ir_scan #(
  parameter int HALF_CYC = 2,
  parameter int IR_W     = 32,
  parameter int CNT_W    = 8,
  parameter int LEN_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IR_W-1:0]  ir_value,
  input  logic [CNT_W-1:0] pre_bits,
  input  logic [LEN_W-1:0] ir_len,
  input  logic [CNT_W-1:0] post_bits,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             tck,
  output logic             tms,
  output logic             tdi
);
  logic load, bit_tms, bit_tdi, bit_end;

  jis_seq #(.IR_W(IR_W), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .ir_value(ir_value),
    .pre_bits(pre_bits), .ir_len(ir_len), .post_bits(post_bits),
    .bit_end(bit_end), .load(load), .bit_tms(bit_tms), .bit_tdi(bit_tdi),
    .busy(busy), .done(done), .err(err)
  );

  jis_tck_gen #(.HALF_CYC(HALF_CYC)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .tms_in(bit_tms), .tdi_in(bit_tdi),
    .bit_end(bit_end), .tck(tck), .tms(tms), .tdi(tdi)
  );
endmodule

// File: rtl/jtag_ir_scan_chk.sv
module jtag_ir_scan_chk #(
  parameter int IR_W  = 32,
  parameter int LEN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] ir_len,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic             tck,
  input logic             tms,
  input logic             tdi
);
  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tck && tdi));
  // R7
  tms_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tms != $past(tms)) |-> !tck);
  // R7
  tdi_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tdi != $past(tdi)) |-> !tck);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R9
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (ir_len == '0 || int'(ir_len) > IR_W)) |=> (err && !busy));
endmodule

bind jtag_ir_scan jtag_ir_scan_chk #(.IR_W(IR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .ir_len(ir_len), .busy(busy),
  .done(done), .err(err), .tck(tck), .tms(tms), .tdi(tdi)
);

// File: tb/tb_jtag_ir_scan.sv
`timescale 1ns/1ps
module tb_jtag_ir_scan;
  localparam int HALF = 2;
  localparam int MAXB = 600;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] ir_value = '0;
  logic [7:0]  pre_bits = '0, post_bits = '0;
  logic [5:0]  ir_len = '0;
  logic busy, done, err, tck, tms, tdi;

  int n_chk = 0, n_bad = 0;
  int cap_n = 0;
  logic cap_tms [MAXB];
  logic cap_tdi [MAXB];
  logic exp_tms [MAXB];
  logic exp_tdi [MAXB];
  int exp_n;
  int low_cyc;

  always #10 clk = ~clk;

  jtag_ir_scan #(.HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ir_value(ir_value),
    .pre_bits(pre_bits), .ir_len(ir_len), .post_bits(post_bits),
    .busy(busy), .done(done), .err(err), .tck(tck), .tms(tms), .tdi(tdi)
  );

  always @(posedge tck) if (rst_n && cap_n < MAXB) begin
    cap_tms[cap_n] = tms;
    cap_tdi[cap_n] = tdi;
    cap_n = cap_n + 1;
  end

  always @(negedge clk) if (rst_n && !tck) low_cyc = low_cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input logic m, input logic d);
    exp_tms[exp_n] = m;
    exp_tdi[exp_n] = d;
    exp_n++;
  endtask

  task automatic build(input logic [31:0] v, input int pre, input int len, input int post);
    exp_n = 0;
    push(1, 1); push(1, 1); push(0, 1); push(0, 1);
    for (int i = 0; i < pre; i++) push(0, 1);
    for (int i = 0; i < len; i++) push((i == len - 1) && (post == 0), v[i]);
    for (int i = 0; i < post; i++) push(i == post - 1, 1);
    push(1, 1); push(0, 1);
  endtask

  task automatic pulse_start(input logic [31:0] v, input int pre, input int len, input int post);
    @(negedge clk);
    ir_value = v; pre_bits = 8'(pre); ir_len = 6'(len); post_bits = 8'(post);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit got_err);
    int t = 0;
    got_err = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    got_err = err;
  endtask

  task automatic scan_test(input string req, input logic [31:0] v, input int pre,
                           input int len, input int post, input bit poke);
    bit e;
    int bad;
    build(v, pre, len, post);
    cap_n = 0;
    low_cyc = 0;
    pulse_start(v, pre, len, post);
    check(busy === 1'b1, "R8 busy after start", int'(busy), 1);
    if (poke) begin
      repeat (20) @(negedge clk);
      ir_value = ~v; pre_bits = 8'd3; ir_len = 6'd5; post_bits = 8'd7;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(e);
    check(e == 1'b0, {req, " R8 done without err"}, int'(e), 0);
    @(negedge clk);
    check(cap_n == exp_n, {req, " R6 period count"}, cap_n, exp_n);
    bad = 0;
    for (int i = 0; i < exp_n && i < cap_n; i++)
      if (cap_tms[i] !== exp_tms[i] || cap_tdi[i] !== exp_tdi[i]) begin
        if (bad == 0)
          $display("FAIL %s stream bit %0d: actual tms/tdi %b%b expected %b%b",
                   req, i, cap_tms[i], cap_tdi[i], exp_tms[i], exp_tdi[i]);
        bad++;
      end
    n_chk++;
    if (bad != 0) n_bad++;
    check(low_cyc == HALF * exp_n, {req, " R7 tck low cycles"}, low_cyc, HALF * exp_n);
    check(tck && tdi && !tms && !busy, {req, " R1 idle pins after scan"},
          {tck, tdi, tms, busy}, 4'b1100);
  endtask

  task automatic bad_len_test(input string req, input int len);
    cap_n = 0;
    @(negedge clk);
    ir_len = 6'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && err, {req, " R9 done+err next cycle"}, {done, err}, 2'b11);
    repeat (10) @(negedge clk);
    check(cap_n == 0 && !busy, {req, " R9 no tck edge"}, cap_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tck && tdi && !tms && !busy && !done, "R1 reset state",
          {tck, tdi, tms, busy, done}, 5'b11000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    scan_test("R2 R4 no pads",        32'h0000_000B, 0, 4, 0, 0);
    scan_test("R3 leading pads",      32'h0000_0015, 5, 5, 0, 0);
    scan_test("R5 trailing pads",     32'h0000_000E, 0, 4, 3, 0);
    scan_test("R5 both pads",         32'h0000_0002, 2, 3, 6, 0);
    scan_test("R4 len 1",             32'h0000_0000, 1, 1, 1, 0);
    scan_test("R4 len 32",            32'hA5C3_0F96, 0, 32, 0, 0);
    scan_test("R10 start while busy", 32'h0000_0031, 4, 6, 4, 1);
    bad_len_test("len 0", 0);
    bad_len_test("len 33", 33);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule